// File: doc/BRIEF.md
# Three-Operand Register Machine Core

This block is a small multi-cycle processor core for a 32-bit instruction word. It holds 64 general registers of 32 bits. The highest register doubles as the program counter, and the lowest one is wiped at the start of every instruction. Each instruction is fetched from a byte-addressed, little-endian memory through a single-outstanding request/response port. The core then splits the word into an opcode and three register selectors and carries out the operation.

The core implements six operations: word load, multiply, shifted-immediate move, conditional move, byte output over a valid/ready port, and stop. Any other opcode value stops the core and flags it as illegal. After reset the core stays idle until `boot_done` is seen. This lets an external engine fill memory first.

The controller is a single state machine with these states:
- `ST_BOOT`: waits for boot. It moves to `ST_FETCH` when `boot_done` is high.
- `ST_FETCH`: issues the fetch request, bumps the program counter and clears register 0. It always moves to `ST_FWAIT`.
- `ST_FWAIT`: moves to `ST_EXEC` on `mem_rvalid`, capturing the instruction.
- `ST_EXEC`: branches on the opcode:
  - multiply, immediate move and conditional move go back to `ST_FETCH`;
  - load goes to `ST_LREQ`;
  - output goes to `ST_OUT`;
  - stop and every unimplemented opcode go to `ST_STOP`.
- `ST_LREQ`: issues the data request and always moves to `ST_LWAIT`.
- `ST_LWAIT`: moves to `ST_FETCH` on `mem_rvalid`, writing the loaded word.
- `ST_OUT`: moves to `ST_FETCH` once `out_ready` is high.
- `ST_STOP`: is terminal.

Top module: `regm_core`

## Requirements
- R1: After reset, `mem_req`, `out_valid`, `halted` and `illegal` are low, and no request is made until `boot_done` has been seen high. The first fetch reads byte address 0.
- R2: Every fetch reads at the address held in register 63. Register 63 is then advanced by 4 before the instruction executes, so an instruction reading register 63 sees the fetch address plus 4. An instruction that writes register 63 redirects the next fetch to the written value.
- R3: Instruction fields are: opcode in bits 31:27, B in bits 26:21, C in bits 20:15, D in bits 14:9.
- R4: Register 0 reads as zero in every instruction. A value written to it is discarded at the next fetch.
- R5: Opcode 2 (load) writes R[B] with the little-endian memory word at byte address R[C]+R[D].
- R6: Opcode 9 (multiply) writes the low 32 bits of R[C]×R[D] into R[B].
- R7: Opcode 16 (immediate move) writes into R[B] the unsigned 16-bit value in bits 20:5, shifted left by the count in bits 4:0 and kept to 32 bits.
- R8: Opcode 18 (conditional move) copies R[C] into R[B] when R[D] is nonzero. When R[D] is zero, no register changes.
- R9: Opcode 25 (output) presents the low byte of R[B] on `out_data` with `out_valid` high. Both are held steady until `out_ready`, and each instruction transfers exactly one byte.
- R10: Opcode 31 (stop) raises `halted`, which stays high, and no further request is made.
- R11: Every opcode other than 2, 9, 16, 18, 25 and 31 raises both `illegal` and `halted`. It writes no register, produces no output and makes no further request.
- R12: `mem_req` is high for a single cycle per access. The core waits any number of cycles for `mem_rvalid` before using `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_done | input | 1 | Memory is loaded; fetching may begin |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_rvalid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 32 | Read data word |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Receiver accepts the byte |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an unimplemented opcode |

## Verification
The bench goes after these corner cases:
- A conditional move whose condition register is register 0, right after register 0 was written. A core that fails to wipe register 0 at fetch would perform the move and print the wrong character.
- Reading register 63 inside an instruction, and writing it to jump over code. A core that advances the program counter after execution, or lets the increment override the write, prints the wrong address byte or runs the skipped output.
- Loads whose address is formed from register 0 plus an offset, and memory latencies that vary from 1 to 3 cycles. A core that misuses stale read data would load the wrong word.
- Output under stalled `out_ready`, which exposes a duplicated or dropped byte.
- An unimplemented opcode followed by an output. This must show the flag and no further traffic.

// File: rtl/regm_pkg.sv
package regm_pkg;

    // Instruction field positions
    localparam int OPC_HI = 31;
    localparam int OPC_LO = 27;
    localparam int FB_HI  = 26;
    localparam int FB_LO  = 21;
    localparam int FC_HI  = 20;
    localparam int FC_LO  = 15;
    localparam int FD_HI  = 14;
    localparam int FD_LO  = 9;
    localparam int IMM_HI = 20;
    localparam int IMM_LO = 5;
    localparam int SH_HI  = 4;
    localparam int SH_LO  = 0;

    // Implemented opcodes
    localparam logic [4:0] OP_LDW  = 5'd2;
    localparam logic [4:0] OP_MUL  = 5'd9;
    localparam logic [4:0] OP_MOVI = 5'd16;
    localparam logic [4:0] OP_CMOV = 5'd18;
    localparam logic [4:0] OP_PUTC = 5'd25;
    localparam logic [4:0] OP_STOP = 5'd31;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_FETCH,
        ST_FWAIT,
        ST_EXEC,
        ST_LREQ,
        ST_LWAIT,
        ST_OUT,
        ST_STOP
    } core_state_e;

endpackage

// File: rtl/regm_regfile.sv
module regm_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 64,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            zero_clr,
    input  logic            pc_step,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   ra_b,
    input  logic [AW-1:0]   ra_c,
    input  logic [AW-1:0]   ra_d,
    output logic [XLEN-1:0] rd_b,
    output logic [XLEN-1:0] rd_c,
    output logic [XLEN-1:0] rd_d,
    output logic [XLEN-1:0] pc
);

    localparam int PC_IDX = NREG - 1;

    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [XLEN-1:0] q;
        logic            hit;
        assign hit = we && (waddr == AW'(g));

        if (g == PC_IDX) begin : g_pc
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       q <= '0;
                else if (hit)     q <= wdata;
                else if (pc_step) q <= q + XLEN'(4);
            end
        end else if (g == 0) begin : g_zero
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        q <= '0;
                else if (hit)      q <= wdata;
                else if (zero_clr) q <= '0;
            end
        end else begin : g_gen
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '0;
                else if (hit) q <= wdata;
            end
        end

        assign regs[g] = q;
    end

    assign rd_b = regs[ra_b];
    assign rd_c = regs[ra_c];
    assign rd_d = regs[ra_d];
    assign pc   = regs[PC_IDX];

endmodule

// File: rtl/regm_alu.sv
module regm_alu
    import regm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] val_c,
    input  logic [XLEN-1:0] val_d,
    output logic [XLEN-1:0] prod,
    output logic [XLEN-1:0] imm_val,
    output logic            cmov_take
);

    logic [XLEN-1:0] imm_raw;

    assign prod      = val_c * val_d;
    assign imm_raw   = XLEN'(instr[IMM_HI:IMM_LO]);
    assign imm_val   = imm_raw << instr[SH_HI:SH_LO];
    assign cmov_take = (val_d != '0);

endmodule

// File: rtl/regm_core.sv
module regm_core
    import regm_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boot_done,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            out_valid,
    output logic [7:0]      out_data,
    input  logic            out_ready,
    output logic            halted,
    output logic            illegal
);

    localparam int AW = $clog2(NREG);

    core_state_e state, state_nx;
    logic [31:0] instr;
    logic        ill_q;

    logic [4:0]    opc;
    logic [AW-1:0] fb, fc, fd;
    assign opc = instr[OPC_HI:OPC_LO];
    assign fb  = instr[FB_HI:FB_LO];
    assign fc  = instr[FC_HI:FC_LO];
    assign fd  = instr[FD_HI:FD_LO];

    logic            rf_we, zero_clr, pc_step;
    logic [XLEN-1:0] rf_wdata, rb, rc, rd, pc;
    logic [XLEN-1:0] prod, imm_val;
    logic            cmov_take;
    logic            opc_known;

    regm_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_clr (zero_clr),
        .pc_step  (pc_step),
        .we       (rf_we),
        .waddr    (fb),
        .wdata    (rf_wdata),
        .ra_b     (fb),
        .ra_c     (fc),
        .ra_d     (fd),
        .rd_b     (rb),
        .rd_c     (rc),
        .rd_d     (rd),
        .pc       (pc)
    );

    regm_alu #(.XLEN(XLEN)) u_alu (
        .instr     (instr),
        .val_c     (rc),
        .val_d     (rd),
        .prod      (prod),
        .imm_val   (imm_val),
        .cmov_take (cmov_take)
    );

    assign opc_known = (opc == OP_LDW) || (opc == OP_MUL) || (opc == OP_MOVI) ||
                       (opc == OP_CMOV) || (opc == OP_PUTC) || (opc == OP_STOP);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BOOT;
            instr <= '0;
            ill_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_FWAIT && mem_rvalid) instr <= mem_rdata[31:0];
            if (state == ST_EXEC && !opc_known)  ill_q <= 1'b1;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT:  if (boot_done) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_FWAIT;
            ST_FWAIT: if (mem_rvalid) state_nx = ST_EXEC;
            ST_EXEC: begin
                if (opc == OP_LDW)                           state_nx = ST_LREQ;
                else if (opc == OP_PUTC)                     state_nx = ST_OUT;
                else if (opc == OP_MUL || opc == OP_MOVI ||
                         opc == OP_CMOV)                     state_nx = ST_FETCH;
                else                                         state_nx = ST_STOP;
            end
            ST_LREQ:  state_nx = ST_LWAIT;
            ST_LWAIT: if (mem_rvalid) state_nx = ST_FETCH;
            ST_OUT:   if (out_ready) state_nx = ST_FETCH;
            ST_STOP:  state_nx = ST_STOP;
            default:  state_nx = ST_STOP;
        endcase
    end

    // Outputs and register-file controls
    always_comb begin
        mem_req   = (state == ST_FETCH) || (state == ST_LREQ);
        mem_addr  = (state == ST_LREQ) ? (rc + rd) : pc;
        zero_clr  = (state == ST_FETCH);
        pc_step   = (state == ST_FETCH);
        out_valid = (state == ST_OUT);
        out_data  = rb[7:0];
        halted    = (state == ST_STOP);
        illegal   = ill_q;
        rf_we     = 1'b0;
        rf_wdata  = prod;
        if (state == ST_LWAIT) begin
            rf_we    = mem_rvalid;
            rf_wdata = mem_rdata;
        end else if (state == ST_EXEC) begin
            if (opc == OP_MUL) begin
                rf_we    = 1'b1;
                rf_wdata = prod;
            end else if (opc == OP_MOVI) begin
                rf_we    = 1'b1;
                rf_wdata = imm_val;
            end else if (opc == OP_CMOV) begin
                rf_we    = cmov_take;
                rf_wdata = rc;
            end
        end
    end

endmodule

// File: rtl/regm_core_chk.sv
module regm_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            boot_done,
    input logic            mem_req,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic [XLEN-1:0] mem_rdata,
    input logic            out_valid,
    input logic [7:0]      out_data,
    input logic            out_ready,
    input logic            halted,
    input logic            illegal
);

    logic boot_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         boot_seen <= 1'b0;
        else if (boot_done) boot_seen <= 1'b1;
    end

    // R1
    no_early_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> boot_seen);

    // R12
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_req && !out_valid));

    // R11
    illegal_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    // R9
    out_not_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && mem_req));

endmodule

bind regm_core regm_core_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_done  (boot_done),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .halted     (halted),
    .illegal    (illegal)
);

// File: tb/regm_core_bench.sv
`timescale 1ns/1ps
module regm_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_done = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic        halted;
    logic        illegal;

    always #4 clk = ~clk;

    regm_core u_regm_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_done  (boot_done),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready),
        .halted     (halted),
        .illegal    (illegal)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] mem [0:255];
    int          wp;
    logic [31:0] exp_addr [$];
    logic [7:0]  exp_byte [$];
    bit          exp_ill;
    int          n_req;

    // R3: opcode 31:27, B 26:21, C 20:15, D 14:9
    function automatic logic [31:0] f_rrr(input int op, input int b, input int c, input int d);
        return {5'(op), 6'(b), 6'(c), 6'(d), 9'd0};
    endfunction

    // R7: opcode 16, immediate 20:5, shift 4:0
    function automatic logic [31:0] f_movi(input int b, input int imm, input int sh);
        return {5'd16, 6'(b), 16'(imm), 5'(sh)};
    endfunction

    task automatic emit(input logic [31:0] w);
        mem[wp] = w;
        wp++;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
        wp = 0;
    endtask

    // Instruction-level reference model
    task automatic run_model();
        logic [31:0] r [64];
        logic [31:0] ins, a;
        int b, c, d;
        for (int i = 0; i < 64; i++) r[i] = '0;
        exp_addr.delete();
        exp_byte.delete();
        exp_ill = 1'b0;
        for (int step = 0; step < 400; step++) begin
            r[0] = '0;
            exp_addr.push_back(r[63]);
            ins = mem[r[63][9:2]];
            r[63] = r[63] + 32'd4;
            b = int'(ins[26:21]);
            c = int'(ins[20:15]);
            d = int'(ins[14:9]);
            case (ins[31:27])
                5'd2: begin
                    a = r[c] + r[d];
                    exp_addr.push_back(a);
                    r[b] = mem[a[9:2]];
                end
                5'd9:  r[b] = r[c] * r[d];
                5'd16: r[b] = {16'd0, ins[20:5]} << ins[4:0];
                5'd18: if (r[d] != 0) r[b] = r[c];
                5'd25: exp_byte.push_back(r[b][7:0]);
                5'd31: begin exp_ill = 1'b0; break; end
                default: begin exp_ill = 1'b1; break; end
            endcase
        end
    endtask

    // Memory responder with latency 1..3, address compared every request
    int          wait_cnt = 0;
    logic [31:0] pend_addr;
    initial begin
        n_req = 0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (!rst_n) begin
                wait_cnt = 0;
            end else begin
                if (wait_cnt > 0) begin
                    wait_cnt--;
                    if (wait_cnt == 0) begin
                        mem_rvalid = 1'b1;
                        mem_rdata  = mem[pend_addr[9:2]];
                    end
                end
                if (mem_req) begin
                    if (exp_addr.size() == 0) begin
                        // R10/R11: no request after stop
                        check(1'b0, "R10/R11 extra request", mem_addr, 32'hx);
                    end else begin
                        logic [31:0] e;
                        e = exp_addr.pop_front();
                        // R2 fetch address, R5 load address
                        check(mem_addr == e, "R2/R5 request address", mem_addr, e);
                    end
                    pend_addr = mem_addr;
                    wait_cnt  = 1 + (n_req % 3);
                    n_req++;
                end
            end
        end
    end

    // Output sink with periodic back-pressure, byte compared every transfer
    int ready_ph = 0;
    initial begin
        forever begin
            @(negedge clk);
            out_ready = (ready_ph % 4 == 0) || (ready_ph % 4 == 3);
            ready_ph++;
            if (rst_n && out_valid && out_ready) begin
                if (exp_byte.size() == 0) begin
                    check(1'b0, "R9 extra output byte", {24'd0, out_data}, 32'hx);
                end else begin
                    logic [7:0] e;
                    e = exp_byte.pop_front();
                    // R4 R6 R7 R8 R9 observed through output bytes
                    check(out_data == e, "R4/R6/R7/R8/R9 output byte", {24'd0, out_data}, {24'd0, e});
                end
            end
        end
    end

    task automatic run_program(input string tag);
        int cyc;
        rst_n     = 1'b0;
        boot_done = 1'b0;
        run_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_req = 0;
        repeat (6) @(negedge clk);
        // R1: idle before boot
        check(mem_req == 1'b0 && out_valid == 1'b0 && n_req == 0, "R1 idle before boot",
              {30'd0, mem_req, out_valid}, 32'd0);
        check(halted == 1'b0 && illegal == 1'b0, "R1 flags clear after reset",
              {30'd0, halted, illegal}, 32'd0);
        boot_done = 1'b1;
        cyc = 0;
        while (!halted && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 5000) begin
            check(1'b0, {"watchdog ", tag}, 32'(cyc), 32'd5000);
        end
        repeat (20) @(negedge clk);
        // R10 / R11: stop state and flag
        check(halted == 1'b1, "R10 halted raised", {31'd0, halted}, 32'd1);
        check(illegal == exp_ill, "R11 illegal flag", {31'd0, illegal}, {31'd0, exp_ill});
        check(exp_addr.size() == 0, "R2/R12 all requests seen", 32'(exp_addr.size()), 32'd0);
        check(exp_byte.size() == 0, "R9 all bytes seen", 32'(exp_byte.size()), 32'd0);
    endtask

    initial begin
        // Program A: every implemented operation, ends with stop
        clear_mem();
        emit(f_movi(1, 16'h41, 0));
        emit(f_rrr(25, 1, 0, 0));
        emit(f_movi(2, 3, 0));
        emit(f_movi(3, 16'h17, 0));
        emit(f_rrr(9, 4, 2, 3));          // R6
        emit(f_rrr(25, 4, 0, 0));
        emit(f_movi(5, 1, 31));           // R7: 0x80000000
        emit(f_movi(6, 16'h5A, 0));
        emit(f_rrr(18, 6, 1, 5));         // R8 taken
        emit(f_rrr(25, 6, 0, 0));
        emit(f_movi(7, 0, 0));
        emit(f_movi(8, 16'h51, 0));
        emit(f_rrr(18, 8, 1, 7));         // R8 not taken
        emit(f_rrr(25, 8, 0, 0));
        emit(f_movi(0, 5, 0));            // R4: write r0
        emit(f_rrr(18, 8, 2, 0));         // R4: r0 must read zero
        emit(f_rrr(25, 8, 0, 0));
        emit(f_movi(9, 16'h1F0, 0));
        emit(f_movi(10, 16'h10, 0));
        emit(f_rrr(2, 11, 9, 10));        // R5 load at 0x200
        emit(f_rrr(25, 11, 0, 0));
        emit(f_movi(12, 16'h81, 2));      // 0x204
        emit(f_rrr(2, 13, 0, 12));        // R5 with r0 base
        emit(f_rrr(25, 13, 0, 0));
        emit(f_movi(14, 16'hABCD, 0));
        emit(f_movi(15, 16'h9876, 4));
        emit(f_rrr(9, 16, 14, 15));       // R6 large operands
        emit(f_rrr(25, 16, 0, 0));
        emit(f_movi(17, 16'h0123, 4));    // R7 shifted
        emit(f_rrr(25, 17, 0, 0));
        emit(f_rrr(25, 63, 0, 0));        // R2: pc reads fetch+4
        emit(f_movi(63, 16'h90, 0));      // R2: jump
        emit(f_rrr(25, 1, 0, 0));         // skipped
        wp = 36;
        emit(f_rrr(25, 2, 0, 0));
        emit(f_rrr(31, 0, 0, 0));         // R10
        mem[128] = 32'h1234_56C3;
        mem[129] = 32'hA5A5_5A3C;
        run_program("A");

        // Program B: unimplemented opcode stops the core (R11)
        clear_mem();
        emit(f_movi(1, 16'h42, 0));
        emit(f_rrr(25, 1, 0, 0));
        emit(f_rrr(8, 1, 1, 1));          // R11: opcode 8 not implemented
        emit(f_rrr(25, 1, 0, 0));
        run_program("B");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule